// File: doc/BRIEF.md
# Half-Bridge First-Come Gate Interlock

This block guards one leg of a half-bridge, and one copy is placed per phase. It takes an ON request for the high-side switch and an ON request for the low-side switch, and it drives two registered gate enables. The two switches are never enabled together. The request that arrives first owns the leg and is passed to its gate. The opposing request is held off while the owner is active. If the opposing request is still asserted when the owner releases, it takes the leg on that same clock edge and no idle cycle is inserted.

Both requests pass through a two-flop synchroniser before arbitration. A three-state controller tracks whether the leg is idle, owned by the high side, or owned by the low side. If both requests are first seen in the same cycle, a parameter decides which side wins, and by default the low side wins. The block does not insert dead time and does not report faults. The controller that issues the requests has to provide any dead time.

Top module: `hbInterlock`

## Requirements
- R1: `gateHi` and `gateLo` are never 1 in the same cycle.
- R2: A gate output is 1 only while its own request, as seen after the synchroniser, is 1. When the owning request drops, its gate turns off.
- R3: While one side owns the leg, asserting or pulsing the opposite request leaves the opposite gate at 0 and does not change the owner's gate.
- R4: When the owner's request drops while the opposite request is still 1, the opposite gate turns on at the same clock edge as the owner's gate turns off, so no cycle has both gates at 0.
- R5: From idle, if both requests become visible in the same cycle, the low side wins when `LOW_WINS_TIE`=1 (the default) and the high side wins when it is 0.
- R6: From idle, a single asserted request turns on its own gate.
- R7: While synchronous reset `rst` is 1, both gates are 0 from the next clock edge onward, and the controller returns to idle.
- R8: A request change applied between clock edges reaches the gate output at the third rising edge after it is applied. This is two synchroniser flops plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdHi | input | 1 | High-side ON request (asynchronous) |
| cmdLo | input | 1 | Low-side ON request (asynchronous) |
| gateHi | output | 1 | High-side gate enable, registered |
| gateLo | output | 1 | Low-side gate enable, registered |

## Verification
Every gate result is due on the third rising edge after a request changes. The bench drives requests on the falling edge and samples on a later falling edge. Each vector in the table is held for four cycles, which is longer than the latency, and is checked at the end of its hold. The directed latency and handover tests sample exactly after the second and third edges. Reset takes effect after one edge and is checked after one edge. The checker keeps its own three-stage copy of the requests, so its properties compare each gate with the request value that the arbiter saw in the same cycle.

// File: rtl/hbInterlockPkg.sv
package hbInterlockPkg;

  typedef enum logic [1:0] {
    LEG_IDLE = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } legState_e;

  // strobes from control to datapath: next value of each gate
  typedef struct packed {
    logic driveHi;
    logic driveLo;
  } gateStrobe_t;

  localparam int SIDE_HI = 1;
  localparam int SIDE_LO = 0;
  localparam int NUM_SIDES = 2;

endpackage

// File: rtl/hbSync.sv
module hbSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hbDatapath.sv
module hbDatapath
  import hbInterlockPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdHi,
  input  logic        cmdLo,
  input  gateStrobe_t strobe,
  output logic        syncHi,
  output logic        syncLo,
  output logic        gateHi,
  output logic        gateLo
);

  logic [NUM_SIDES-1:0] rawCmd;
  logic [NUM_SIDES-1:0] syncCmd;

  assign rawCmd[SIDE_HI] = cmdHi;
  assign rawCmd[SIDE_LO] = cmdLo;

  generate
    for (genvar side = 0; side < NUM_SIDES; side++) begin : g_side
      hbSync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rawCmd[side]),
        .dout (syncCmd[side])
      );
    end
  endgenerate

  assign syncHi = syncCmd[SIDE_HI];
  assign syncLo = syncCmd[SIDE_LO];

  // registered gate outputs, loaded from the control strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      gateHi <= 1'b0;
      gateLo <= 1'b0;
    end else begin
      gateHi <= strobe.driveHi;
      gateLo <= strobe.driveLo;
    end
  end

endmodule

// File: rtl/hbControl.sv
module hbControl
  import hbInterlockPkg::*;
#(
  parameter bit LOW_WINS_TIE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        syncHi,
  input  logic        syncLo,
  output gateStrobe_t strobe
);

  legState_e legState;
  legState_e legNext;
  legState_e tieWinner;

  generate
    if (LOW_WINS_TIE) begin : g_tieLow
      assign tieWinner = LEG_LOW;
    end else begin : g_tieHigh
      assign tieWinner = LEG_HIGH;
    end
  endgenerate

  always_comb begin
    legNext = legState;
    unique case (legState)
      LEG_IDLE: begin
        if (syncHi && syncLo) legNext = tieWinner;
        else if (syncHi)      legNext = LEG_HIGH;
        else if (syncLo)      legNext = LEG_LOW;
        else                  legNext = LEG_IDLE;
      end
      LEG_HIGH: begin
        if (!syncHi) legNext = syncLo ? LEG_LOW : LEG_IDLE;
      end
      LEG_LOW: begin
        if (!syncLo) legNext = syncHi ? LEG_HIGH : LEG_IDLE;
      end
      default: legNext = LEG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) legState <= LEG_IDLE;
    else     legState <= legNext;
  end

  always_comb begin
    strobe.driveHi = (legNext == LEG_HIGH);
    strobe.driveLo = (legNext == LEG_LOW);
  end

endmodule

// File: rtl/hbInterlock.sv
module hbInterlock
  import hbInterlockPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter bit LOW_WINS_TIE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cmdHi,
  input  logic cmdLo,
  output logic gateHi,
  output logic gateLo
);

  gateStrobe_t strobe;
  logic        syncHi;
  logic        syncLo;

  hbDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .cmdHi  (cmdHi),
    .cmdLo  (cmdLo),
    .strobe (strobe),
    .syncHi (syncHi),
    .syncLo (syncLo),
    .gateHi (gateHi),
    .gateLo (gateLo)
  );

  hbControl #(.LOW_WINS_TIE(LOW_WINS_TIE)) u_control (
    .clk    (clk),
    .rst    (rst),
    .syncHi (syncHi),
    .syncLo (syncLo),
    .strobe (strobe)
  );

endmodule

// File: rtl/hbInterlockChecker.sv
module hbInterlockChecker #(
  parameter int SYNC_STAGES  = 2,
  parameter bit LOW_WINS_TIE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic cmdHi,
  input logic cmdLo,
  input logic gateHi,
  input logic gateLo
);

  // independent delay line: refHi/refLo equal the request value the
  // arbiter acted on for the gate value visible in the same cycle
  logic [SYNC_STAGES:0] hiPipe;
  logic [SYNC_STAGES:0] loPipe;
  logic refHi;
  logic refLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiPipe <= '0;
      loPipe <= '0;
    end else begin
      hiPipe <= {hiPipe[SYNC_STAGES-1:0], cmdHi};
      loPipe <= {loPipe[SYNC_STAGES-1:0], cmdLo};
    end
  end

  assign refHi = hiPipe[SYNC_STAGES];
  assign refLo = loPipe[SYNC_STAGES];

  a_r1_never_both: assert property (@(posedge clk) disable iff (rst)
    !(gateHi && gateLo));

  a_r2_hi_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    gateHi |-> refHi);

  a_r2_lo_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    gateLo |-> refLo);

  a_r3_hi_owner_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(gateHi) && refHi) |-> gateHi);

  a_r3_lo_owner_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(gateLo) && refLo) |-> gateLo);

  a_r4_hand_to_lo: assert property (@(posedge clk) disable iff (rst)
    ($past(gateHi) && !refHi && refLo) |-> gateLo);

  a_r4_hand_to_hi: assert property (@(posedge clk) disable iff (rst)
    ($past(gateLo) && !refLo && refHi) |-> gateHi);

  a_r5_tie_break: assert property (@(posedge clk) disable iff (rst)
    (!$past(gateHi) && !$past(gateLo) && refHi && refLo)
      |-> (LOW_WINS_TIE ? gateLo : gateHi));

  a_r6_idle_single: assert property (@(posedge clk) disable iff (rst)
    (!$past(gateHi) && !$past(gateLo) && (refHi != refLo))
      |-> (gateHi == refHi && gateLo == refLo));

  a_r7_reset_off: assert property (@(posedge clk)
    rst |=> (!gateHi && !gateLo));

endmodule

bind hbInterlock hbInterlockChecker #(
  .SYNC_STAGES  (SYNC_STAGES),
  .LOW_WINS_TIE (LOW_WINS_TIE)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cmdHi  (cmdHi),
  .cmdLo  (cmdLo),
  .gateHi (gateHi),
  .gateLo (gateLo)
);

// File: tb/hbInterlock_tb.sv
module hbInterlock_tb;

  localparam int HOLD = 4;
  localparam int NVEC = 13;
  // {cmdHi, cmdLo, expHi, expLo}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b00_00, 4'b10_10, 4'b11_10, 4'b01_01, 4'b11_01, 4'b10_10,
    4'b00_00, 4'b01_01, 4'b00_00, 4'b11_01, 4'b10_10, 4'b11_10,
    4'b00_00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdHi = 1'b0;
  logic cmdLo = 1'b0;
  logic gateHi;
  logic gateLo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hbInterlock u_dut (
    .clk(clk), .rst(rst), .cmdHi(cmdHi), .cmdLo(cmdLo),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates {hi,lo} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 never both", {gateHi && gateLo, 1'b0}, 2'b00);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset state", {gateHi, gateLo}, 2'b00);
    rst = 1'b0;
    cycles(2);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      cmdHi = VEC[v][3];
      cmdLo = VEC[v][2];
      cycles(HOLD);
      check($sformatf("R2-R6 table vec %0d (R3 R4 R5 R6)", v), {gateHi, gateLo}, VEC[v][1:0]);
    end

    // R8 latency from idle
    cmdHi = 1'b1;
    cycles(2);
    check("R8 not yet after 2 edges", {gateHi, gateLo}, 2'b00);
    cycles(1);
    check("R8 on after 3 edges", {gateHi, gateLo}, 2'b10);

    // R3 short opposite pulse while high owns
    cmdLo = 1'b1;
    cycles(1);
    cmdLo = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cycles(1);
      check("R3 pulse ignored", {gateHi, gateLo}, 2'b10);
    end

    // R4 handover with no gap
    cmdLo = 1'b1;
    cycles(HOLD);
    cmdHi = 1'b0;
    cycles(2);
    check("R4 before handover", {gateHi, gateLo}, 2'b10);
    cycles(1);
    check("R4 handover same edge", {gateHi, gateLo}, 2'b01);

    // R2 owner drop with nothing pending -> off after latency
    cmdLo = 1'b0;
    cycles(2);
    check("R2 still on at 2 edges", {gateHi, gateLo}, 2'b01);
    cycles(1);
    check("R2 off at 3 edges", {gateHi, gateLo}, 2'b00);

    // R7 reset while owning
    cmdHi = 1'b1;
    cycles(HOLD);
    check("R7 pre-reset owner", {gateHi, gateLo}, 2'b10);
    rst = 1'b1;
    cycles(1);
    check("R7 reset forces off", {gateHi, gateLo}, 2'b00);
    cmdHi = 1'b0;
    cmdLo = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(HOLD);
    check("R7 idle after reset, R6 lo passes", {gateHi, gateLo}, 2'b01);

    // R5 tie again from idle
    cmdLo = 1'b0;
    cycles(HOLD);
    cmdHi = 1'b1;
    cmdLo = 1'b1;
    cycles(3);
    check("R5 tie low wins", {gateHi, gateLo}, 2'b01);
    cmdHi = 1'b0;
    cmdLo = 1'b0;
    cycles(HOLD);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule